// File: doc/BRIEF.md
# Decode Steering Unit

This block sits between instruction predecode and the micro-op queue. Each cycle it looks at a window of predecoded instructions and hands them, strictly in program order, to four decoder slots: three that take single-micro-op instructions and one that can produce up to four micro-ops. Each instruction arrives with its class and its micro-op count already tagged. Instructions that need more micro-ops go to a microcode sequencer. The sequencer streams their micro-ops over the following cycles. While it does so, no new instruction is taken.

Two kinds of fusion raise throughput. A compare directly followed by a conditional branch becomes one fused branch entry, which needs only one slot. One such pair per cycle lets the four slots consume five instructions. A memory-destination ALU instruction is cracked into a fused load-plus-ALU micro-op, a store-address micro-op and a store-data micro-op. Each cycle the block reports how many window entries it consumed, so the feeder can advance the window. It also emits the micro-ops, packed in program order, with a valid bit per lane.

Top module: `decode_steer`

## Requirements
- R1: A synchronous active-high reset clears `consumed`, all `uop_vld` lanes and any sequencer activity. While reset is held, these outputs stay zero whatever the window holds.
- R2: Steering follows program order. The first entry that is invalid, or that cannot be placed, ends the cycle's group and every later entry waits. Emitted micro-ops fill lanes from lane 0 upward with no gaps, in order of their source position. `uop_src` gives that source position.
- R3: A single-micro-op entry takes a free single-micro-op slot and emits kind 0 (simple). Once all three are used, it may take the multi-micro-op slot and emits kind 2 (complex). Class is `win_cls`: 0 plain, 1 compare, 2 conditional branch, 3 memory-destination ALU. The micro-op count of a plain entry is `win_ucnt`+1.
- R4: A plain entry with 2 to 4 micro-ops needs the multi-micro-op slot and emits that many kind-2 lanes. The multi-micro-op slot takes at most one entry per cycle.
- R5: A compare whose next window position holds a valid conditional branch is fused with it. The pair emits one kind-1 lane with the compare's position and uses one slot. Both entries count toward `consumed`, so up to five instructions are consumed in a cycle.
- R6: At most one pair is fused per cycle; a second compare-branch pair decodes as two single entries. A compare with no valid branch right after it, including one in the last window position, is decoded alone.
- R7: A memory-destination ALU entry uses the multi-micro-op slot. It emits three consecutive lanes: kind 3 (load+ALU), kind 4 (store address) and kind 5 (store data).
- R8: An entry needing more than four micro-ops is accepted only at window position 0, and then alone: `consumed`=1 and four kind-6 lanes with source 0. Later cycles each emit up to four more kind-6 lanes until the count is exhausted. Elsewhere in the window such an entry ends the group before it.
- R9: While the sequencer still has micro-ops to emit, `consumed` is 0 and the window contents have no effect on the outputs.
- R10: All outputs are registered. The result for a window appears after the first rising clock edge at which that window is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_vld | input | 6 | Valid bit per window position |
| win_cls | input | 12 | 2-bit class per position |
| win_ucnt | input | 24 | 4-bit micro-op count minus one per position |
| consumed | output | 3 | Window entries consumed by the sampled window |
| uop_vld | output | 7 | Valid bit per emitted micro-op lane |
| uop_kind | output | 21 | 3-bit micro-op kind per lane |
| uop_src | output | 21 | 3-bit source window position per lane |

## Verification
Every steering result is due one rising edge after its window is sampled. The bench therefore drives each window on a falling edge and compares all outputs on the next falling edge. A sequencer instruction gives its first four micro-ops at that same edge and one further chunk at each following edge. The bench checks those chunks edge by edge, with `consumed` at zero, while a different window is held on the inputs. The window held during the drain is then checked on the edge right after the last chunk.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;

  // kind of each emitted micro-op lane
  typedef enum logic [2:0] {
    UK_SIMPLE = 3'd0,
    UK_FUSED  = 3'd1,
    UK_CMPLX  = 3'd2,
    UK_LDALU  = 3'd3,
    UK_STADDR = 3'd4,
    UK_STDATA = 3'd5,
    UK_MSEQ   = 3'd6
  } uop_kind_e;

  // predecode class of a window entry
  typedef enum logic [1:0] {
    IC_PLAIN = 2'd0,
    IC_CMP   = 2'd1,
    IC_JCC   = 2'd2,
    IC_RMW   = 2'd3
  } icls_e;

  // how an accepted entry expands into lanes
  typedef enum logic [2:0] {
    EN_NONE,
    EN_SIMPLE,
    EN_FUSED,
    EN_CMPLX,
    EN_RMW,
    EN_MSEQ
  } ent_e;

endpackage

// File: rtl/steer_alloc.sv
module steer_alloc
  import dsteer_pkg::*;
#(
  parameter int WIN     = 6,
  parameter int NSIMPLE = 3,
  parameter int CMAX    = 4,
  parameter int UCW     = 4,
  parameter int NUW     = 5
) (
  input  logic [WIN-1:0]     vld,
  input  logic [2*WIN-1:0]   cls,
  input  logic [UCW*WIN-1:0] ucnt,
  input  logic               busy,
  input  logic [NUW-1:0]     chunk,
  output logic [WIN-1:0]     take,
  output logic [WIN-1:0]     lead,
  output ent_e               ekind [WIN],
  output logic [NUW-1:0]     enu   [WIN],
  output logic               msq_start,
  output logic [NUW-1:0]     msq_total
);

  function automatic logic [NUW-1:0] need_of(input logic [1:0] c, input logic [UCW-1:0] u);
    case (icls_e'(c))
      IC_RMW:         need_of = NUW'(3);
      IC_CMP, IC_JCC: need_of = NUW'(1);
      default:        need_of = NUW'(u) + NUW'(1);
    endcase
  endfunction

  logic [WIN-1:0]          nxt_jcc;
  logic [WIN-1:0][NUW-1:0] need;

  generate
    for (genvar i = 0; i < WIN; i++) begin : g_pos
      assign need[i] = need_of(cls[2*i +: 2], ucnt[UCW*i +: UCW]);
      if (i < WIN-1) begin : g_nx
        assign nxt_jcc[i] = vld[i+1] && (icls_e'(cls[2*(i+1) +: 2]) == IC_JCC);
      end else begin : g_last
        assign nxt_jcc[i] = 1'b0;
      end
    end
  endgenerate

  int   nsimp;
  logic cused, fused, stop, skip, fz;

  always_comb begin
    take      = '0;
    lead      = '0;
    msq_start = 1'b0;
    msq_total = '0;
    for (int i = 0; i < WIN; i++) begin
      ekind[i] = EN_NONE;
      enu[i]   = '0;
    end
    nsimp = 0;
    cused = 1'b0;
    fused = 1'b0;
    stop  = 1'b0;
    skip  = 1'b0;
    fz    = 1'b0;
    if (busy) begin
      // sequencer drains: lanes carry its next chunk, window untouched
      lead[0]  = 1'b1;
      ekind[0] = EN_MSEQ;
      enu[0]   = chunk;
    end else begin
      for (int i = 0; i < WIN; i++) begin
        fz = (icls_e'(cls[2*i +: 2]) == IC_CMP) && nxt_jcc[i] && !fused;
        if (stop) begin
          fz = 1'b0;
        end else if (skip) begin
          take[i] = 1'b1;          // branch half of a fused pair
          skip    = 1'b0;
        end else if (!vld[i]) begin
          stop = 1'b1;
        end else if (need[i] > NUW'(CMAX)) begin
          if (i == 0) begin
            take[i]   = 1'b1;
            lead[i]   = 1'b1;
            ekind[i]  = EN_MSEQ;
            enu[i]    = NUW'(CMAX);
            msq_start = 1'b1;
            msq_total = need[i];
          end
          stop = 1'b1;
        end else if (need[i] == NUW'(1) && nsimp < NSIMPLE) begin
          nsimp    = nsimp + 1;
          take[i]  = 1'b1;
          lead[i]  = 1'b1;
          ekind[i] = fz ? EN_FUSED : EN_SIMPLE;
          enu[i]   = NUW'(1);
          if (fz) begin
            fused = 1'b1;
            skip  = 1'b1;
          end
        end else if (!cused) begin
          cused    = 1'b1;
          take[i]  = 1'b1;
          lead[i]  = 1'b1;
          enu[i]   = need[i];
          if (fz) ekind[i] = EN_FUSED;
          else if (icls_e'(cls[2*i +: 2]) == IC_RMW) ekind[i] = EN_RMW;
          else ekind[i] = EN_CMPLX;
          if (fz) begin
            fused = 1'b1;
            skip  = 1'b1;
          end
        end else begin
          stop = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lane_pack.sv
module lane_pack
  import dsteer_pkg::*;
#(
  parameter int WIN   = 6,
  parameter int NLANE = 7,
  parameter int NUW   = 5,
  parameter int SRCW  = 3,
  parameter int CMAX  = 4
) (
  input  logic [WIN-1:0]        lead,
  input  ent_e                  ekind [WIN],
  input  logic [NUW-1:0]        enu   [WIN],
  output logic [NLANE-1:0]      lane_vld,
  output logic [3*NLANE-1:0]    lane_kind,
  output logic [SRCW*NLANE-1:0] lane_src
);

  function automatic logic [2:0] kind_of(input ent_e ek, input int j);
    case (ek)
      EN_FUSED: kind_of = UK_FUSED;
      EN_CMPLX: kind_of = UK_CMPLX;
      EN_MSEQ:  kind_of = UK_MSEQ;
      EN_RMW:   kind_of = (j == 0) ? UK_LDALU : ((j == 1) ? UK_STADDR : UK_STDATA);
      default:  kind_of = UK_SIMPLE;
    endcase
  endfunction

  int base;

  always_comb begin
    lane_vld  = '0;
    lane_kind = '0;
    lane_src  = '0;
    base      = 0;
    for (int i = 0; i < WIN; i++) begin
      if (lead[i]) begin
        for (int j = 0; j < CMAX; j++) begin
          if (NUW'(j) < enu[i] && (base + j) < NLANE) begin
            lane_vld[base+j]               = 1'b1;
            lane_kind[3*(base+j) +: 3]     = kind_of(ekind[i], j);
            lane_src[SRCW*(base+j) +: SRCW] = SRCW'(i);
          end
        end
        base = base + int'(enu[i]);
      end
    end
  end

endmodule

// File: rtl/msq_track.sv
module msq_track #(
  parameter int NUW  = 5,
  parameter int CMAX = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NUW-1:0] total,
  output logic           busy,
  output logic [NUW-1:0] chunk
);

  logic [NUW-1:0] rem;

  assign busy  = (rem != '0);
  assign chunk = (rem > NUW'(CMAX)) ? NUW'(CMAX) : rem;

  always_ff @(posedge clk) begin
    if (rst)        rem <= '0;
    else if (start) rem <= total - NUW'(CMAX);
    else if (busy)  rem <= rem - chunk;
  end

  // R8: a new long instruction is only taken once the previous one drained
  assert_idle_start_R8: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R9: every busy cycle brings the sequencer closer to idle
  assert_drain_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (rem < $past(rem)));

endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import dsteer_pkg::*;
#(
  parameter int WIN     = 6,
  parameter int NSIMPLE = 3,
  parameter int CMAX    = 4,
  parameter int UCW     = 4,
  localparam int NLANE  = NSIMPLE + CMAX,
  localparam int SRCW   = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int CONSW  = $clog2(NSIMPLE + 3),
  localparam int NUW    = $clog2((1 << UCW) + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WIN-1:0]          win_vld,
  input  logic [2*WIN-1:0]        win_cls,
  input  logic [UCW*WIN-1:0]      win_ucnt,
  output logic [CONSW-1:0]        consumed,
  output logic [NLANE-1:0]        uop_vld,
  output logic [3*NLANE-1:0]      uop_kind,
  output logic [SRCW*NLANE-1:0]   uop_src
);

  logic [WIN-1:0]        take, lead;
  ent_e                  ekind [WIN];
  logic [NUW-1:0]        enu   [WIN];
  logic                  msq_start, msq_busy;
  logic [NUW-1:0]        msq_total, msq_chunk;
  logic [NLANE-1:0]      lane_vld;
  logic [3*NLANE-1:0]    lane_kind;
  logic [SRCW*NLANE-1:0] lane_src;

  steer_alloc #(
    .WIN(WIN), .NSIMPLE(NSIMPLE), .CMAX(CMAX), .UCW(UCW), .NUW(NUW)
  ) u_alloc (
    .vld(win_vld), .cls(win_cls), .ucnt(win_ucnt),
    .busy(msq_busy), .chunk(msq_chunk),
    .take(take), .lead(lead), .ekind(ekind), .enu(enu),
    .msq_start(msq_start), .msq_total(msq_total)
  );

  lane_pack #(
    .WIN(WIN), .NLANE(NLANE), .NUW(NUW), .SRCW(SRCW), .CMAX(CMAX)
  ) u_pack (
    .lead(lead), .ekind(ekind), .enu(enu),
    .lane_vld(lane_vld), .lane_kind(lane_kind), .lane_src(lane_src)
  );

  msq_track #(.NUW(NUW), .CMAX(CMAX)) u_msq (
    .clk(clk), .rst(rst), .start(msq_start), .total(msq_total),
    .busy(msq_busy), .chunk(msq_chunk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      consumed <= '0;
      uop_vld  <= '0;
      uop_kind <= '0;
      uop_src  <= '0;
    end else begin
      consumed <= CONSW'($countones(take));
      uop_vld  <= lane_vld;
      uop_kind <= lane_kind;
      uop_src  <= lane_src;
    end
  end

  // ---- checks on the registered outputs ----
  int   simple_lanes;
  logic any_fused;
  always_comb begin
    simple_lanes = 0;
    any_fused    = 1'b0;
    for (int k = 0; k < NLANE; k++) begin
      if (uop_vld[k] && uop_kind[3*k +: 3] == UK_SIMPLE) simple_lanes = simple_lanes + 1;
      if (uop_vld[k] && uop_kind[3*k +: 3] == UK_FUSED)  any_fused    = 1'b1;
    end
  end

  // R3: never more simple-decoder micro-ops than simple slots
  assert_simple_cap_R3: assert property (@(posedge clk) disable iff (rst)
    simple_lanes <= NSIMPLE);

  // R5: four slots plus one fused pair bound the consumed count
  assert_cons_cap_R5: assert property (@(posedge clk) disable iff (rst)
    int'(consumed) <= NSIMPLE + 2);

  // R5: a fused lane stands for two consumed instructions
  assert_fused_cons_R5: assert property (@(posedge clk) disable iff (rst)
    any_fused |-> consumed >= CONSW'(2));

  // R9: nothing is consumed while the sequencer drains
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    msq_busy |=> consumed == '0);

  generate
    for (genvar k = 0; k < NLANE-1; k++) begin : g_lchk
      // R2: valid lanes form a prefix
      assert_lane_prefix_R2: assert property (@(posedge clk) disable iff (rst)
        uop_vld[k+1] |-> uop_vld[k]);
    end
    for (genvar k = 0; k < NLANE-2; k++) begin : g_rchk
      // R7: load+ALU is followed by store address then store data
      assert_rmw_order_R7: assert property (@(posedge clk) disable iff (rst)
        (uop_vld[k] && uop_kind[3*k +: 3] == UK_LDALU) |->
          (uop_vld[k+2] && uop_kind[3*(k+1) +: 3] == UK_STADDR &&
           uop_kind[3*(k+2) +: 3] == UK_STDATA));
    end
  endgenerate

endmodule

// File: tb/decode_steer_bench.sv
`timescale 1ns/1ps
module decode_steer_bench;

  localparam int W  = 6;
  localparam int NL = 7;

  typedef struct packed {
    logic [5:0]  v;
    logic [11:0] cls;
    logic [23:0] uc;
    logic [2:0]  cons;
    logic [6:0]  lv;
    logic [20:0] kind;
    logic [20:0] src;
  } tvec_t;

  localparam int NV = 14;
  localparam tvec_t VECS [NV] = '{
    // 0 R3: six plain singles, 4th goes to complex slot
    '{6'b111111, 12'h000, 24'h000000, 3'd4, 7'b0001111,
      {3'd0,3'd0,3'd0,3'd2,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd3,3'd2,3'd1,3'd0}},
    // 1 R4: 3-uop head then singles
    '{6'b111111, 12'h000, 24'h000002, 3'd4, 7'b0111111,
      {3'd0,3'd0,3'd0,3'd0,3'd2,3'd2,3'd2}, {3'd0,3'd3,3'd2,3'd1,3'd0,3'd0,3'd0}},
    // 2 R5: cmp+jcc fused, five consumed
    '{6'b111111, 12'h009, 24'h000000, 3'd5, 7'b0001111,
      {3'd0,3'd0,3'd0,3'd2,3'd0,3'd0,3'd1}, {3'd0,3'd0,3'd0,3'd4,3'd3,3'd2,3'd0}},
    // 3 R6: second pair not fused
    '{6'b111111, 12'h099, 24'h000000, 3'd5, 7'b0001111,
      {3'd0,3'd0,3'd0,3'd2,3'd0,3'd0,3'd1}, {3'd0,3'd0,3'd0,3'd4,3'd3,3'd2,3'd0}},
    // 4 R7: rmw at head
    '{6'b111111, 12'h003, 24'h000000, 3'd4, 7'b0111111,
      {3'd0,3'd0,3'd0,3'd0,3'd5,3'd4,3'd3}, {3'd0,3'd3,3'd2,3'd1,3'd0,3'd0,3'd0}},
    // 5 R7: rmw mid-window, later 2-uop blocked (R2)
    '{6'b111111, 12'h030, 24'h010000, 3'd4, 7'b0111111,
      {3'd0,3'd0,3'd5,3'd4,3'd3,3'd0,3'd0}, {3'd0,3'd3,3'd2,3'd2,3'd2,3'd1,3'd0}},
    // 6 R2: invalid entry ends group
    '{6'b111011, 12'h000, 24'h000000, 3'd2, 7'b0000011,
      {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd1,3'd0}},
    // 7 R6: cmp without following branch decoded alone; all 7 lanes
    '{6'b001111, 12'h040, 24'h000003, 3'd4, 7'b1111111,
      {3'd0,3'd0,3'd0,3'd2,3'd2,3'd2,3'd2}, {3'd3,3'd2,3'd1,3'd0,3'd0,3'd0,3'd0}},
    // 8 R5: lone jcc then fused pair at position 1
    '{6'b111111, 12'h026, 24'h000000, 3'd5, 7'b0001111,
      {3'd0,3'd0,3'd0,3'd2,3'd0,3'd1,3'd0}, {3'd0,3'd0,3'd0,3'd4,3'd3,3'd1,3'd0}},
    // 9 R8: long instruction not at head ends group
    '{6'b111111, 12'h000, 24'h000070, 3'd1, 7'b0000001,
      {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}},
    // 10 R4: two multi-uop entries, only one taken
    '{6'b111111, 12'h000, 24'h000011, 3'd1, 7'b0000011,
      {3'd0,3'd0,3'd0,3'd0,3'd0,3'd2,3'd2}, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}},
    // 11 R2: empty window
    '{6'b000000, 12'h000, 24'h000000, 3'd0, 7'b0000000, 21'h0, 21'h0},
    // 12 R5: pair lands in complex slot after simples fill
    '{6'b111111, 12'h240, 24'h000000, 3'd5, 7'b0001111,
      {3'd0,3'd0,3'd0,3'd1,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd3,3'd2,3'd1,3'd0}},
    // 13 R5: 4-uop head, fused pair, two singles
    '{6'b111111, 12'h024, 24'h000003, 3'd5, 7'b1111111,
      {3'd0,3'd0,3'd1,3'd2,3'd2,3'd2,3'd2}, {3'd4,3'd3,3'd1,3'd0,3'd0,3'd0,3'd0}}
  };

  string vtag [NV] = '{"R3", "R4", "R5", "R6", "R7", "R7", "R2", "R6",
                       "R5", "R8", "R4", "R2", "R5", "R5"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  win_vld  = '0;
  logic [11:0] win_cls  = '0;
  logic [23:0] win_ucnt = '0;
  logic [2:0]  consumed;
  logic [6:0]  uop_vld;
  logic [20:0] uop_kind;
  logic [20:0] uop_src;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  decode_steer u_decode_steer (
    .clk(clk), .rst(rst), .win_vld(win_vld), .win_cls(win_cls), .win_ucnt(win_ucnt),
    .consumed(consumed), .uop_vld(uop_vld), .uop_kind(uop_kind), .uop_src(uop_src)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [2:0] c, input logic [6:0] lv,
                           input logic [20:0] k, input logic [20:0] s);
    check(req, "consumed", 32'(consumed), 32'(c));
    check(req, "uop_vld",  32'(uop_vld),  32'(lv));
    check(req, "uop_kind", 32'(uop_kind), 32'(k));
    check(req, "uop_src",  32'(uop_src),  32'(s));
  endtask

  function automatic logic [20:0] mseq_kinds(input int n);
    logic [20:0] r = '0;
    for (int l = 0; l < n; l++) r[3*l +: 3] = 3'd6;
    return r;
  endfunction

  function automatic logic [6:0] lanes(input int n);
    logic [6:0] r = '0;
    for (int l = 0; l < n; l++) r[l] = 1'b1;
    return r;
  endfunction

  task automatic drive(input logic [5:0] v, input logic [11:0] c, input logic [23:0] u);
    win_vld  = v;
    win_cls  = c;
    win_ucnt = u;
  endtask

  task automatic check_plain6(input string req);
    check_out(req, VECS[0].cons, VECS[0].lv, VECS[0].kind, VECS[0].src);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a full window
    drive(6'b111111, 12'h000, 24'h000000);
    repeat (3) @(negedge clk);
    check_out("R1", 3'd0, 7'd0, 21'h0, 21'h0);
    rst = 1'b0;

    // table walk (R10: each result one edge after the window)
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      drive(VECS[n].v, VECS[n].cls, VECS[n].uc);
      @(negedge clk);
      check_out(vtag[n], VECS[n].cons, VECS[n].lv, VECS[n].kind, VECS[n].src);
    end

    // R8/R9: 10-uop instruction, window changes during drain
    @(negedge clk);
    drive(6'b111111, 12'h000, 24'h000009);
    @(negedge clk);
    check_out("R8", 3'd1, lanes(4), mseq_kinds(4), 21'h0);
    drive(6'b111111, 12'h000, 24'h000000);
    @(negedge clk);
    check_out("R9", 3'd0, lanes(4), mseq_kinds(4), 21'h0);
    @(negedge clk);
    check_out("R9", 3'd0, lanes(2), mseq_kinds(2), 21'h0);
    @(negedge clk);
    check_plain6("R9");

    // R8: exactly five micro-ops, one-lane tail
    drive(6'b111111, 12'h000, 24'h000004);
    @(negedge clk);
    check_out("R8", 3'd1, lanes(4), mseq_kinds(4), 21'h0);
    drive(6'b111111, 12'h000, 24'h000000);
    @(negedge clk);
    check_out("R8", 3'd0, lanes(1), mseq_kinds(1), 21'h0);
    @(negedge clk);
    check_plain6("R8");

    // R8: largest count, 16 micro-ops over four cycles
    drive(6'b000001, 12'h000, 24'h00000F);
    @(negedge clk);
    check_out("R8", 3'd1, lanes(4), mseq_kinds(4), 21'h0);
    drive(6'b111111, 12'h003, 24'h000000);
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      check_out("R9", 3'd0, lanes(4), mseq_kinds(4), 21'h0);
    end
    @(negedge clk);
    check_out("R7", VECS[4].cons, VECS[4].lv, VECS[4].kind, VECS[4].src);

    // R1: reset in the middle of a drain cancels it
    drive(6'b000001, 12'h000, 24'h00000F);
    @(negedge clk);
    check_out("R8", 3'd1, lanes(4), mseq_kinds(4), 21'h0);
    rst = 1'b1;
    drive(6'b111111, 12'h000, 24'h000000);
    @(negedge clk);
    check_out("R1", 3'd0, 7'd0, 21'h0, 21'h0);
    rst = 1'b0;
    @(negedge clk);
    check_plain6("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule